// File: doc/BRIEF.md
# Object Handle Hash Table Engine

This block keeps a table that maps a 32-bit object handle, together with a channel id, to a 32-bit context word. The table lives in an internal RAM of `2**IDX_W` slots. Each slot holds two words: the handle and the context word. A slot in which both words are zero is empty. A requester issues one of three operations over a valid/ready handshake. Insert packs a context word from a channel, an engine id and an instance address, then stores it. Lookup returns hit or miss and the stored context word. Remove clears a slot that the requester names.

The start slot is computed from the handle and the channel. The handle is cut into `IDX_W`-bit pieces and the pieces are XORed together. The channel id is then XORed in at a shifted position. Collisions are resolved by linear probing, which wraps from the last slot back to slot 0. An insert that comes back to its start slot without finding a free slot reports a full table. The slot index used by an insert is returned, so a later remove can name that slot. A mode input chooses between two layouts of the context word.

Top module: `ht_engine`

## Requirements
- R1: A slot is empty exactly when both its handle word and its context word are zero. After reset every slot is empty, so a lookup of any handle misses.
- R2: The start slot is computed in three steps. First, h = XOR of the consecutive `IDX_W`-bit chunks of the handle, lowest chunk first; the last chunk is zero-padded. Second, h is XORed with (channel << (IDX_W-4)). Third, the result is truncated to `IDX_W` bits.
- R3: Insert stores into the first empty slot found from the start slot, moving upward by 1 and wrapping from slot `2**IDX_W-1` to slot 0. It responds with `rsp_hit_o`=1, `rsp_full_o`=0, the slot index used, and the context word written.
- R4: An insert that finds no empty slot in a full wrap responds with `rsp_full_o`=1 and `rsp_hit_o`=0, and it leaves the table unchanged.
- R5: With `new_layout_i`=0 the context word is built as follows: bit 31 is 1, bits 28:24 hold the channel, bits 17:16 hold the engine, bits 15:0 hold instance address bits 19:4, and all other bits are 0.
- R6: With `new_layout_i`=1 the context word is built as follows: bits 21:20 hold the engine, bits 15:0 hold instance address bits 19:4, and all other bits are 0.
- R7: Lookup probes from the start slot in the same order as insert. It hits on the first non-empty slot whose handle word equals the request handle, and it returns that slot and its context word. It misses on reaching an empty slot or after a full wrap, and then returns a context word of 0.
- R8: Remove writes zero to both words of slot `req_slot_i`. It responds with hit=0, full=0, context 0 and the slot it cleared.
- R9: Operation codes on `req_op_i` are 0 = lookup, 1 = insert, 2 = remove. `req_ready_o` is high exactly when `busy_o` is low. A request is accepted when valid and ready are both high. Each accepted request produces exactly one single-cycle `rsp_valid_o` pulse.
- R10: During and after reset `req_ready_o`=1, `busy_o`=0 and `rsp_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request can be accepted |
| req_op_i | input | 2 | 0 lookup, 1 insert, 2 remove |
| req_chan_i | input | CH_W | Channel id |
| req_handle_i | input | 32 | Object handle |
| req_engine_i | input | 2 | Engine id for insert |
| req_inst_i | input | 20 | Instance byte address for insert |
| req_slot_i | input | IDX_W | Slot to clear on remove |
| new_layout_i | input | 1 | Context word layout select |
| busy_o | output | 1 | Request in progress |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Lookup hit or insert stored |
| rsp_full_o | output | 1 | Insert found no free slot |
| rsp_slot_o | output | IDX_W | Slot used or matched |
| rsp_ctx_o | output | 32 | Context word |

## Verification
The hardest situation to reach from the ports is a long probe chain that wraps past the top of the table and then ends at the starting slot. Such a chain is needed to exercise the full-table insert, the full-wrap lookup miss, and a lookup cut short by a hole that a remove left mid-chain. The bench uses a 16-slot configuration and builds handles whose nibbles cancel pairwise, so that all of them hash to the same slot. Sixteen such inserts fill the table through the wrap. A reference model derived from the hash and probe rules predicts every slot index and context word.

// File: rtl/ht_pkg.sv
package ht_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_REMOVE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_CLEAR
  } state_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned INST_W = 20;
endpackage

// File: rtl/ht_hash.sv
module ht_hash #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CH_W  = 5
) (
  input  logic [31:0]      handle_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned NCHUNK = (32 + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = NCHUNK * IDX_W;
  localparam int unsigned MIX_W  = IDX_W + CH_W;

  logic [PAD_W-1:0] padded;
  logic [MIX_W-1:0] mix;
  logic [IDX_W-1:0] fold;

  assign padded = PAD_W'(handle_i);
  assign mix    = MIX_W'(chan_i) << (IDX_W - 4);

  always_comb begin
    fold = '0;
    for (int k = 0; k < NCHUNK; k++) fold ^= padded[k*IDX_W +: IDX_W];
  end

  assign idx_o = fold ^ mix[IDX_W-1:0];
endmodule

// File: rtl/ht_ctx_pack.sv
module ht_ctx_pack #(
  parameter int unsigned CH_W = 5
) (
  input  logic [CH_W-1:0]          chan_i,
  input  logic [1:0]               engine_i,
  input  logic [ht_pkg::INST_W-1:0] inst_i,
  input  logic                     new_layout_i,
  output logic [31:0]              ctx_o
);
  logic [4:0]  chan5;
  logic [15:0] inst_f;

  assign chan5  = 5'(chan_i);
  assign inst_f = inst_i[19:4];

  always_comb begin
    ctx_o = '0;
    ctx_o[15:0] = inst_f;
    if (new_layout_i) begin
      ctx_o[21:20] = engine_i;
    end else begin
      ctx_o[31]    = 1'b1;
      ctx_o[28:24] = chan5;
      ctx_o[17:16] = engine_i;
    end
  end
endmodule

// File: rtl/ht_slot_ram.sv
module ht_slot_ram #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [31:0]      rd_handle_o,
  output logic [31:0]      rd_ctx_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [31:0]      wr_handle_i,
  input  logic [31:0]      wr_ctx_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [31:0] handle_mem [DEPTH];
  logic [31:0] ctx_mem    [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        handle_mem[i] <= '0;
        ctx_mem[i]    <= '0;
      end
      rd_handle_o <= '0;
      rd_ctx_o    <= '0;
    end else begin
      if (wr_en_i) begin
        handle_mem[wr_addr_i] <= wr_handle_i;
        ctx_mem[wr_addr_i]    <= wr_ctx_i;
      end
      rd_handle_o <= handle_mem[rd_addr_i];
      rd_ctx_o    <= ctx_mem[rd_addr_i];
    end
  end
endmodule

// File: rtl/ht_engine.sv
module ht_engine
  import ht_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CH_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [CH_W-1:0]   req_chan_i,
  input  logic [31:0]       req_handle_i,
  input  logic [1:0]        req_engine_i,
  input  logic [INST_W-1:0] req_inst_i,
  input  logic [IDX_W-1:0]  req_slot_i,
  input  logic              new_layout_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_full_o,
  output logic [IDX_W-1:0]  rsp_slot_o,
  output logic [31:0]       rsp_ctx_o
);
  state_e            state_q;
  op_e               op_q;
  logic [31:0]       handle_q, ctx_q;
  logic [IDX_W-1:0]  start_q, probe_q, clr_slot_q;
  logic [IDX_W-1:0]  hash_idx, probe_nxt;
  logic [31:0]       ctx_new, rd_handle, rd_ctx;
  logic              slot_empty, wrapped, ins_store;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [31:0]       wr_handle, wr_ctx;

  ht_hash #(.IDX_W(IDX_W), .CH_W(CH_W)) u_hash (
    .handle_i(req_handle_i), .chan_i(req_chan_i), .idx_o(hash_idx)
  );

  ht_ctx_pack #(.CH_W(CH_W)) u_pack (
    .chan_i(req_chan_i), .engine_i(req_engine_i), .inst_i(req_inst_i),
    .new_layout_i(new_layout_i), .ctx_o(ctx_new)
  );

  ht_slot_ram #(.IDX_W(IDX_W)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_addr_i(probe_q), .rd_handle_o(rd_handle), .rd_ctx_o(rd_ctx),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_handle_i(wr_handle), .wr_ctx_i(wr_ctx)
  );

  assign slot_empty = (rd_handle == '0) && (rd_ctx == '0);
  assign probe_nxt  = probe_q + IDX_W'(1);
  assign wrapped    = (probe_nxt == start_q);
  assign ins_store  = (state_q == ST_CHECK) && (op_q == OP_INSERT) && slot_empty;

  always_comb begin
    wr_en     = 1'b0;
    wr_addr   = probe_q;
    wr_handle = '0;
    wr_ctx    = '0;
    if (ins_store) begin
      wr_en     = 1'b1;
      wr_handle = handle_q;
      wr_ctx    = ctx_q;
    end else if (state_q == ST_CLEAR) begin
      wr_en   = 1'b1;
      wr_addr = clr_slot_q;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_LOOKUP;
      handle_q    <= '0;
      ctx_q       <= '0;
      start_q     <= '0;
      probe_q     <= '0;
      clr_slot_q  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_full_o  <= 1'b0;
      rsp_slot_o  <= '0;
      rsp_ctx_o   <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            op_q       <= op_e'(req_op_i);
            handle_q   <= req_handle_i;
            ctx_q      <= ctx_new;
            start_q    <= hash_idx;
            probe_q    <= hash_idx;
            clr_slot_q <= req_slot_i;
            state_q    <= (op_e'(req_op_i) == OP_REMOVE) ? ST_CLEAR : ST_READ;
          end
        end
        ST_READ: state_q <= ST_CHECK;
        ST_CHECK: begin
          if (slot_empty) begin
            rsp_valid_o <= 1'b1;
            rsp_full_o  <= 1'b0;
            rsp_slot_o  <= probe_q;
            rsp_hit_o   <= (op_q == OP_INSERT);
            rsp_ctx_o   <= (op_q == OP_INSERT) ? ctx_q : '0;
            state_q     <= ST_IDLE;
          end else if (op_q == OP_LOOKUP && rd_handle == handle_q) begin
            rsp_valid_o <= 1'b1;
            rsp_full_o  <= 1'b0;
            rsp_hit_o   <= 1'b1;
            rsp_slot_o  <= probe_q;
            rsp_ctx_o   <= rd_ctx;
            state_q     <= ST_IDLE;
          end else if (wrapped) begin
            rsp_valid_o <= 1'b1;
            rsp_hit_o   <= 1'b0;
            rsp_full_o  <= (op_q == OP_INSERT);
            rsp_slot_o  <= start_q;
            rsp_ctx_o   <= '0;
            state_q     <= ST_IDLE;
          end else begin
            probe_q <= probe_nxt;
            state_q <= ST_READ;
          end
        end
        ST_CLEAR: begin
          rsp_valid_o <= 1'b1;
          rsp_hit_o   <= 1'b0;
          rsp_full_o  <= 1'b0;
          rsp_slot_o  <= clr_slot_q;
          rsp_ctx_o   <= '0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ht_engine_chk.sv
module ht_engine_chk #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CH_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              busy_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_full_o,
  input logic [IDX_W-1:0]  rsp_slot_o,
  input logic [31:0]       rsp_ctx_o
);
  a_r9_ready_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o != busy_o);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r9_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> busy_o);

  a_r9_rsp_after_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(busy_o));

  a_r4_full_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_full_o) |-> !rsp_hit_o);

  a_r7_miss_zero_ctx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_ctx_o == '0));

  a_r10_idle_after_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (req_ready_o && !busy_o && !rsp_valid_o));
endmodule

bind ht_engine ht_engine_chk #(.IDX_W(IDX_W), .CH_W(CH_W)) u_chk (.*);

// File: tb/ht_engine_tb.sv
module ht_engine_tb;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned CH_W  = 5;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [1:0]        req_op_i = '0;
  logic [CH_W-1:0]   req_chan_i = '0;
  logic [31:0]       req_handle_i = '0;
  logic [1:0]        req_engine_i = '0;
  logic [19:0]       req_inst_i = '0;
  logic [IDX_W-1:0]  req_slot_i = '0;
  logic              new_layout_i = 1'b0;
  logic              busy_o, rsp_valid_o, rsp_hit_o, rsp_full_o;
  logic [IDX_W-1:0]  rsp_slot_o;
  logic [31:0]       rsp_ctx_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_h [DEPTH];
  logic [31:0] m_c [DEPTH];

  always #2 clk_i = ~clk_i;

  ht_engine #(.IDX_W(IDX_W), .CH_W(CH_W)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] m_hash(input logic [31:0] h, input logic [CH_W-1:0] ch);
    logic [31:0] r = 0;
    logic [31:0] t = h;
    for (int i = 32; i > 0; i -= IDX_W) begin
      r ^= t & ((32'd1 << IDX_W) - 1);
      t >>= IDX_W;
    end
    r ^= 32'(ch) << (IDX_W - 4);
    return r[IDX_W-1:0];
  endfunction

  function automatic logic [31:0] m_ctx(input logic [CH_W-1:0] ch, input logic [1:0] e,
                                        input logic [19:0] inst, input bit nl);
    if (nl) return (32'(e) << 20) | 32'(inst[19:4]);
    return 32'h8000_0000 | (32'(ch) << 24) | (32'(e) << 16) | 32'(inst[19:4]);
  endfunction

  task automatic issue(input logic [1:0] op, input logic [CH_W-1:0] ch, input logic [31:0] h,
                       input logic [1:0] e, input logic [19:0] inst, input logic [IDX_W-1:0] s,
                       input bit nl);
    @(negedge clk_i);
    req_op_i = op; req_chan_i = ch; req_handle_i = h; req_engine_i = e;
    req_inst_i = inst; req_slot_i = s; new_layout_i = nl; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk_i);
  endtask

  task automatic do_insert(input logic [CH_W-1:0] ch, input logic [31:0] h,
                           input logic [1:0] e, input logic [19:0] inst, input bit nl);
    logic [IDX_W-1:0] p = m_hash(h, ch);
    bit found = 0;
    logic [IDX_W-1:0] slot = 0;
    logic [31:0] c = m_ctx(ch, e, inst, nl);
    for (int n = 0; n < DEPTH; n++) begin
      if (!found && m_h[p] == 0 && m_c[p] == 0) begin found = 1; slot = p; end
      p = p + 1'b1;
    end
    issue(2'd1, ch, h, e, inst, '0, nl);
    if (found) begin
      m_h[slot] = h; m_c[slot] = c;
      chk(rsp_hit_o && !rsp_full_o, "R3 insert stored", {30'd0, rsp_hit_o, rsp_full_o}, 32'd2);
      chk(rsp_slot_o == slot, "R3 insert slot", 32'(rsp_slot_o), 32'(slot));
      chk(rsp_ctx_o == c, nl ? "R6 ctx layout" : "R5 ctx layout", rsp_ctx_o, c);
    end else begin
      chk(!rsp_hit_o && rsp_full_o, "R4 insert full", {30'd0, rsp_hit_o, rsp_full_o}, 32'd1);
    end
  endtask

  task automatic do_lookup(input logic [CH_W-1:0] ch, input logic [31:0] h);
    logic [IDX_W-1:0] p = m_hash(h, ch);
    bit stop = 0, hit = 0;
    logic [IDX_W-1:0] slot = 0;
    for (int n = 0; n < DEPTH; n++) begin
      if (!stop) begin
        if (m_h[p] == 0 && m_c[p] == 0) stop = 1;
        else if (m_h[p] == h) begin stop = 1; hit = 1; slot = p; end
      end
      p = p + 1'b1;
    end
    issue(2'd0, ch, h, 2'd0, 20'd0, '0, 1'b0);
    chk(rsp_hit_o == hit && !rsp_full_o, "R7 lookup hit", 32'(rsp_hit_o), 32'(hit));
    if (hit) begin
      chk(rsp_slot_o == slot, "R7 lookup slot", 32'(rsp_slot_o), 32'(slot));
      chk(rsp_ctx_o == m_c[slot], "R7 lookup ctx", rsp_ctx_o, m_c[slot]);
    end else begin
      chk(rsp_ctx_o == 0, "R7 miss ctx", rsp_ctx_o, 32'd0);
    end
  endtask

  task automatic do_remove(input logic [IDX_W-1:0] s);
    issue(2'd2, '0, 32'd0, 2'd0, 20'd0, s, 1'b0);
    m_h[s] = 0; m_c[s] = 0;
    chk(!rsp_hit_o && !rsp_full_o && rsp_slot_o == s && rsp_ctx_o == 0, "R8 remove rsp",
        32'(rsp_slot_o), 32'(s));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_h[i] = 0; m_c[i] = 0; end
    #1;
    chk(req_ready_o && !busy_o && !rsp_valid_o, "R10 in reset",
        {29'd0, req_ready_o, busy_o, rsp_valid_o}, 32'd4);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !busy_o && !rsp_valid_o, "R10 after reset",
        {29'd0, req_ready_o, busy_o, rsp_valid_o}, 32'd4);
    // R1 empty table misses
    do_lookup(5'd3, 32'hDEAD_BEEF);
    do_lookup(5'd0, 32'd0);
    // R2 hash sweep: single entry lands on its hash slot
    for (int k = 0; k < 64; k++) begin
      logic [31:0] h = 32'(k) * 32'h9E37_79B1 + 32'd1;
      logic [CH_W-1:0] ch = CH_W'(k);
      do_insert(ch, h, 2'(k), 20'(k * 32'h1_2340), k[0]);
      chk(rsp_slot_o == m_hash(h, ch), "R2 hash slot", 32'(rsp_slot_o), 32'(m_hash(h, ch)));
      do_lookup(ch, h);
      do_remove(rsp_slot_o);
    end
    // R5 R6 layouts per engine and mode
    for (int e = 0; e < 4; e++) begin
      for (int nl = 0; nl < 2; nl++) begin
        do_insert(5'd17, 32'h0ABC_0000 + 32'(e * 2 + nl), 2'(e), 20'hF_EDC8, nl[0]);
        do_lookup(5'd17, 32'h0ABC_0000 + 32'(e * 2 + nl));
        do_remove(rsp_slot_o);
      end
    end
    // R3 collision chain wrapping, R4 full
    for (int j = 0; j < 16; j++) do_insert(5'd0, (32'(j) << 8) | (32'(j) << 12) | 32'h3, 2'd1, 20'h1_0000, 1'b0);
    do_insert(5'd0, 32'h0001_1003, 2'd2, 20'h2_0000, 1'b0);
    do_lookup(5'd0, 32'h0001_1003);
    for (int j = 0; j < 16; j++) do_lookup(5'd0, (32'(j) << 8) | (32'(j) << 12) | 32'h3);
    // R8 hole mid chain
    do_remove(4'd5);
    do_lookup(5'd0, 32'h0000_2203);
    do_lookup(5'd0, 32'h0000_5503);
    do_insert(5'd0, 32'h0000_2203, 2'd3, 20'h3_0000, 1'b1);
    do_lookup(5'd0, 32'h0000_5503);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule